// File: doc/BRIEF.md
# Steerable Time-of-Day Counter

This block keeps a time-of-day value as a 48-bit seconds count and a nanoseconds count. On every system clock the nanoseconds advance by a programmable increment. The increment has an integer-nanosecond part and a 32-bit binary fraction. A fraction accumulator carries into the nanoseconds, and the nanoseconds wrap at one billion into the seconds.

Software steers the counter through a word-wide register port. The port offers three controls. A staged time can be loaded directly. The increment can be trimmed to change the rate. A signed offset can be added to the increment for an exact number of cycles, after which the nominal rate returns by itself. This gives a gradual and precise change of phase.

Rising edges of an alignment input are synchronized and timestamped. A pulse-per-second output of programmable width starts at each seconds rollover.

Top module: `tod_counter`

## Requirements
- R1: After reset the time is 0 s / 0 ns, the fraction is 0, the increment is 8 ns + 0 fraction, no timed adjustment runs, the pulse width register is 0, the capture registers are 0, and `pps_o` and `cap_valid_o` are low. Counting starts on the first edge after reset is released.
- R2: On each clock the ns field grows by the integer increment (register 4) plus the carry out of the 32-bit fraction accumulator, to which the fraction increment (register 5) is added. A value written to register 4 or 5 is used from the next edge.
- R3: When the ns sum reaches 1,000,000,000 or more, the ns field takes the sum minus 1,000,000,000 and the seconds field grows by one, in the same edge.
- R4: A write of any value to register 3 loads the staged ns (register 0) and the staged seconds (register 1 holds the low 32 bits, register 2 the high 16 bits) on that edge and clears the fraction. Reading registers 0, 1 and 2 returns the live time.
- R5: A write of N to register 7 adds the signed offset of register 6, in units of 2^-24 ns, to the increment for exactly the N following cycles. Register 7 reads back the remaining count, and the nominal rate resumes when it reaches 0.
- R6: A negative offset (two's complement) slows the counter by the same amount that the opposite positive offset speeds it up.
- R7: A load through register 3 while a timed adjustment runs cancels it. The remaining count reads 0 and the nominal increment applies from the next edge.
- R8: On the edge where the seconds roll over, `pps_o` rises and stays high for W cycles, W being register 8. With W = 0 no pulse appears.
- R9: A rising edge of `align_i` passes through a 2-flop synchronizer. The third clock edge after the input rises stores the time held during the preceding cycle into `cap_ns_o`/`cap_sec_o`, which also read at registers 9, 10 and 11. `cap_valid_o` is high for that one cycle.
- R10: A falling edge of `align_i`, or a level held high, makes no capture. `cap_valid_o` stays low and the captured value is unchanged.
- R11: Registers 4, 5, 6 and 8 read back the last value written. `rdata_o` follows `addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 4 | register address for write and read |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for `addr_i` |
| align_i | input | 1 | asynchronous alignment input to timestamp |
| pps_o | output | 1 | pulse-per-second output |
| cap_valid_o | output | 1 | one-cycle strobe on a new timestamp |
| cap_ns_o | output | 30 | captured nanoseconds |
| cap_sec_o | output | 48 | captured seconds |

## Verification
A load or a register write acts on the edge that samples it. The bench therefore reads the live time 1 ns after that edge and then counts whole edges before comparing against hand-computed totals of the increment and the carries. The pulse output is sampled on the rollover edge and on the edges W-1 and W after it. For a timestamp, the ns value is read one cycle before the third edge after the input rises. The strobe and the captured value are checked right after that edge, and the strobe is checked low again one edge later. All samples are taken 1 ns after a rising edge, and stimulus is driven on falling edges.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME_NS    = 4'd0,
    A_SEC_LO     = 4'd1,
    A_SEC_HI     = 4'd2,
    A_LOAD       = 4'd3,
    A_INC_NS     = 4'd4,
    A_INC_FRAC   = 4'd5,
    A_ADJ_OFS    = 4'd6,
    A_ADJ_CYC    = 4'd7,
    A_PPS_W      = 4'd8,
    A_CAP_NS     = 4'd9,
    A_CAP_SEC_LO = 4'd10,
    A_CAP_SEC_HI = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int FRAC_W      = 32,
  parameter int INC_NS_W    = 4,
  parameter int INC_NS_RST  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NS_W-1:0]          time_ns_i,
  input  logic [SEC_W-1:0]         time_sec_i,
  input  logic [NS_W-1:0]          cap_ns_i,
  input  logic [SEC_W-1:0]         cap_sec_i,
  output logic                     load_o,
  output logic [NS_W-1:0]          load_ns_o,
  output logic [SEC_W-1:0]         load_sec_o,
  output logic [INC_NS_W-1:0]      inc_ns_o,
  output logic [FRAC_W-1:0]        inc_frac_o,
  output logic                     adj_active_o,
  output logic signed [DATA_W-1:0] adj_ofs_o,
  output logic [DATA_W-1:0]        pps_width_o
);
  localparam int SEC_HI_W = SEC_W - DATA_W;

  reg_addr_e            addr;
  logic                 wr_ns, wr_sec_lo, wr_sec_hi, wr_inc_ns, wr_inc_frac;
  logic                 wr_ofs, wr_cyc, wr_pps;
  logic [NS_W-1:0]      stage_ns_q;
  logic [DATA_W-1:0]    stage_sec_lo_q;
  logic [SEC_HI_W-1:0]  stage_sec_hi_q;
  logic [DATA_W-1:0]    adj_rem_q;

  assign addr        = reg_addr_e'(addr_i);
  assign wr_ns       = wr_en_i && addr == A_TIME_NS;
  assign wr_sec_lo   = wr_en_i && addr == A_SEC_LO;
  assign wr_sec_hi   = wr_en_i && addr == A_SEC_HI;
  assign load_o      = wr_en_i && addr == A_LOAD;
  assign wr_inc_ns   = wr_en_i && addr == A_INC_NS;
  assign wr_inc_frac = wr_en_i && addr == A_INC_FRAC;
  assign wr_ofs      = wr_en_i && addr == A_ADJ_OFS;
  assign wr_cyc      = wr_en_i && addr == A_ADJ_CYC;
  assign wr_pps      = wr_en_i && addr == A_PPS_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_ns_q     <= '0;
      stage_sec_lo_q <= '0;
      stage_sec_hi_q <= '0;
      inc_ns_o       <= INC_NS_W'(INC_NS_RST);
      inc_frac_o     <= '0;
      adj_ofs_o      <= '0;
      pps_width_o    <= '0;
    end else begin
      if (wr_ns)       stage_ns_q     <= wdata_i[NS_W-1:0];
      if (wr_sec_lo)   stage_sec_lo_q <= wdata_i;
      if (wr_sec_hi)   stage_sec_hi_q <= wdata_i[SEC_HI_W-1:0];
      if (wr_inc_ns)   inc_ns_o       <= wdata_i[INC_NS_W-1:0];
      if (wr_inc_frac) inc_frac_o     <= wdata_i[FRAC_W-1:0];
      if (wr_ofs)      adj_ofs_o      <= wdata_i;
      if (wr_pps)      pps_width_o    <= wdata_i;
    end
  end

  // timed adjustment: load cancels, write arms, otherwise count down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                adj_rem_q <= '0;
    else if (load_o)            adj_rem_q <= '0;
    else if (wr_cyc)            adj_rem_q <= wdata_i;
    else if (adj_rem_q != '0)   adj_rem_q <= adj_rem_q - 1'b1;
  end

  assign adj_active_o = adj_rem_q != '0;
  assign load_ns_o    = stage_ns_q;
  assign load_sec_o   = {stage_sec_hi_q, stage_sec_lo_q};

  always_comb begin
    case (addr)
      A_TIME_NS:    rdata_o = DATA_W'(time_ns_i);
      A_SEC_LO:     rdata_o = time_sec_i[DATA_W-1:0];
      A_SEC_HI:     rdata_o = DATA_W'(time_sec_i[SEC_W-1:DATA_W]);
      A_INC_NS:     rdata_o = DATA_W'(inc_ns_o);
      A_INC_FRAC:   rdata_o = DATA_W'(inc_frac_o);
      A_ADJ_OFS:    rdata_o = adj_ofs_o;
      A_ADJ_CYC:    rdata_o = adj_rem_q;
      A_PPS_W:      rdata_o = pps_width_o;
      A_CAP_NS:     rdata_o = DATA_W'(cap_ns_i);
      A_CAP_SEC_LO: rdata_o = cap_sec_i[DATA_W-1:0];
      A_CAP_SEC_HI: rdata_o = DATA_W'(cap_sec_i[SEC_W-1:DATA_W]);
      default:      rdata_o = '0;
    endcase
  end

  // R7: a load leaves no adjustment running
  p_load_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !adj_active_o);

  // R5: remaining count drops by exactly one per cycle while running
  p_adj_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_active_o && !load_o && !wr_cyc) |=> adj_rem_q == $past(adj_rem_q) - 1'b1);
endmodule

// File: rtl/tod_time.sv
module tod_time #(
  parameter int SEC_W     = 48,
  parameter int NS_W      = 30,
  parameter int FRAC_W    = 32,
  parameter int INC_NS_W  = 4,
  parameter int DATA_W    = 32,
  parameter int ADJ_SHIFT = 8,
  parameter int NS_ROLL   = 1000000000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NS_W-1:0]          load_ns_i,
  input  logic [SEC_W-1:0]         load_sec_i,
  input  logic [INC_NS_W-1:0]      inc_ns_i,
  input  logic [FRAC_W-1:0]        inc_frac_i,
  input  logic                     adj_active_i,
  input  logic signed [DATA_W-1:0] adj_ofs_i,
  output logic [NS_W-1:0]          ns_o,
  output logic [SEC_W-1:0]         sec_o,
  output logic                     rollover_o
);
  localparam int BASE_W = INC_NS_W + FRAC_W + 1;
  localparam int OFS_W  = DATA_W + ADJ_SHIFT + 1;
  localparam int STEP_W = (BASE_W > OFS_W ? BASE_W : OFS_W) + 1;
  localparam int ADD_W  = STEP_W + 1 - FRAC_W;

  logic [FRAC_W-1:0]        frac_q;
  logic signed [STEP_W-1:0] base_s, ofs_x, step_s;
  logic [STEP_W-1:0]        step_u;
  logic [STEP_W:0]          acc;
  logic [ADD_W-1:0]         ns_add;
  logic [NS_W:0]            ns_sum;
  logic                     wrap;
  logic [NS_W-1:0]          ns_nxt;

  always_comb begin
    base_s = STEP_W'({inc_ns_i, inc_frac_i});
    ofs_x  = STEP_W'(adj_ofs_i);
    ofs_x  = ofs_x <<< ADJ_SHIFT;
    step_s = adj_active_i ? base_s + ofs_x : base_s;
    // a net negative rate holds the time still
    step_u = step_s[STEP_W-1] ? '0 : step_s;
    acc    = (STEP_W+1)'(step_u) + (STEP_W+1)'(frac_q);
    ns_add = acc[STEP_W:FRAC_W];
    ns_sum = (NS_W+1)'(ns_o) + (NS_W+1)'(ns_add);
    wrap   = ns_sum >= (NS_W+1)'(NS_ROLL);
    ns_nxt = wrap ? NS_W'(ns_sum - (NS_W+1)'(NS_ROLL)) : NS_W'(ns_sum);
  end

  assign rollover_o = wrap && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      ns_o   <= '0;
      sec_o  <= '0;
    end else if (load_i) begin
      frac_q <= '0;
      ns_o   <= load_ns_i;
      sec_o  <= load_sec_i;
    end else begin
      frac_q <= acc[FRAC_W-1:0];
      ns_o   <= ns_nxt;
      if (wrap) sec_o <= sec_o + 1'b1;
    end
  end

  // R3: without a load, seconds either hold or step by one
  p_sec_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + SEC_W'(1)));
endmodule

// File: rtl/tod_pps.sv
module tod_pps #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rollover_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pps_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (rollover_i)     cnt_q <= width_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pps_o = cnt_q != '0;

  // R8: a rollover with nonzero width raises the pulse on the next cycle
  p_pps_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollover_i && width_i != '0) |=> pps_o);
endmodule

// File: rtl/tod_capture.sv
module tod_capture #(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             align_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic             valid_o,
  output logic [NS_W-1:0]  cap_ns_o,
  output logic [SEC_W-1:0] cap_sec_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], align_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      cap_ns_o  <= '0;
      cap_sec_o <= '0;
    end else begin
      valid_o <= rise;
      if (rise) begin
        cap_ns_o  <= ns_i;
        cap_sec_o <= sec_i;
      end
    end
  end

  // R9: the strobe never lasts two cycles
  p_cap_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10: a low synchronized level makes no strobe
  p_no_cap_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q[SYNC_STAGES-1] |=> !valid_o);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int FRAC_W      = 32,
  parameter int INC_NS_W    = 4,
  parameter int INC_NS_RST  = 8,
  parameter int ADJ_SHIFT   = 8,
  parameter int NS_ROLL     = 1000000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              align_i,
  output logic              pps_o,
  output logic              cap_valid_o,
  output logic [NS_W-1:0]   cap_ns_o,
  output logic [SEC_W-1:0]  cap_sec_o
);
  logic                     load;
  logic [NS_W-1:0]          load_ns, time_ns;
  logic [SEC_W-1:0]         load_sec, time_sec;
  logic [INC_NS_W-1:0]      inc_ns;
  logic [FRAC_W-1:0]        inc_frac;
  logic                     adj_active;
  logic signed [DATA_W-1:0] adj_ofs;
  logic [DATA_W-1:0]        pps_width;
  logic                     rollover;

  tod_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
    .INC_NS_W(INC_NS_W), .INC_NS_RST(INC_NS_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .time_ns_i(time_ns), .time_sec_i(time_sec),
    .cap_ns_i(cap_ns_o), .cap_sec_i(cap_sec_o),
    .load_o(load), .load_ns_o(load_ns), .load_sec_o(load_sec),
    .inc_ns_o(inc_ns), .inc_frac_o(inc_frac),
    .adj_active_o(adj_active), .adj_ofs_o(adj_ofs), .pps_width_o(pps_width)
  );

  tod_time #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_NS_W(INC_NS_W),
    .DATA_W(DATA_W), .ADJ_SHIFT(ADJ_SHIFT), .NS_ROLL(NS_ROLL)
  ) u_time (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .load_ns_i(load_ns), .load_sec_i(load_sec),
    .inc_ns_i(inc_ns), .inc_frac_i(inc_frac),
    .adj_active_i(adj_active), .adj_ofs_i(adj_ofs),
    .ns_o(time_ns), .sec_o(time_sec), .rollover_o(rollover)
  );

  tod_pps #(.CNT_W(DATA_W)) u_pps (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rollover_i(rollover), .width_i(pps_width), .pps_o(pps_o)
  );

  tod_capture #(
    .SEC_W(SEC_W), .NS_W(NS_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .align_i(align_i),
    .ns_i(time_ns), .sec_i(time_sec),
    .valid_o(cap_valid_o), .cap_ns_o(cap_ns_o), .cap_sec_o(cap_sec_o)
  );
endmodule

// File: tb/tod_counter_tb.sv
`timescale 1ns/100ps
module tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        align = 1'b0;
  logic        pps;
  logic        cap_valid;
  logic [29:0] cap_ns;
  logic [47:0] cap_sec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .align_i(align), .pps_o(pps),
    .cap_valid_o(cap_valid), .cap_ns_o(cap_ns), .cap_sec_o(cap_sec)
  );

  // trim vectors: inc_ns, inc_frac, load_ns, cycles, expected ns, expected second step
  localparam int NV = 5;
  localparam logic [31:0] V_INC   [NV] = '{32'd8, 32'd6, 32'd2, 32'd4, 32'd7};
  localparam logic [31:0] V_FRAC  [NV] = '{32'h0, 32'h66666666, 32'h80000000, 32'h0, 32'hC0000000};
  localparam logic [31:0] V_LOAD  [NV] = '{32'd100, 32'd0, 32'd1000, 32'd999999990, 32'd999999999};
  localparam int          V_CYC   [NV] = '{10, 5, 7, 3, 4};
  localparam logic [31:0] V_EXPNS [NV] = '{32'd180, 32'd31, 32'd1017, 32'd2, 32'd30};
  localparam logic [31:0] V_EXPS  [NV] = '{32'd0, 32'd0, 32'd0, 32'd1, 32'd1};

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_time(input logic [31:0] ns, input logic [31:0] sec);
    wr(4'd0, ns);
    wr(4'd1, sec);
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(pps, 0, "R1 pps");
    chk(cap_valid, 0, "R1 cap_valid");
    rd(4'd4, r); chk(r, 8, "R1 inc_ns");
    rd(4'd5, r); chk(r, 0, "R1 inc_frac");
    rd(4'd0, r); chk(r, 0, "R1 ns held");
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    rd(4'd0, r); chk(r, 32, "R1 ns after 4 edges");
    rd(4'd7, r); chk(r, 0, "R1 adj idle");
    rd(4'd9, r); chk(r, 0, "R1 cap_ns");
    rd(4'd8, r); chk(r, 0, "R1 pps width");

    // R2 R3 R4: table walk
    for (int i = 0; i < NV; i++) begin
      wr(4'd4, V_INC[i]);
      wr(4'd5, V_FRAC[i]);
      load_time(V_LOAD[i], 32'd5);
      rd(4'd0, r); chk(r, V_LOAD[i], "R4 loaded ns");
      rd(4'd1, r); chk(r, 5, "R4 loaded sec");
      tick(V_CYC[i]);
      rd(4'd0, r); chk(r, V_EXPNS[i], "R2 ns after trim");
      rd(4'd1, r); chk(r, 5 + V_EXPS[i], "R3 seconds");
    end

    // R11: readback
    wr(4'd4, 32'd8);
    wr(4'd5, 32'd0);
    wr(4'd6, 32'h00800000);
    wr(4'd8, 32'd4);
    rd(4'd6, r); chk(r, 32'h00800000, "R11 offset readback");
    rd(4'd8, r); chk(r, 4, "R11 pps width readback");
    rd(4'd4, r); chk(r, 8, "R11 inc readback");

    // R5: +0.5 ns for 10 cycles
    load_time(32'd0, 32'd5);
    wr(4'd7, 32'd10);
    rd(4'd0, r); chk(r, 8, "R5 ns at arm");
    rd(4'd7, r); chk(r, 10, "R5 remaining at arm");
    tick(5);
    rd(4'd7, r); chk(r, 5, "R5 remaining mid");
    tick(15);
    rd(4'd0, r); chk(r, 173, "R5 ns after adjust");
    rd(4'd7, r); chk(r, 0, "R5 remaining done");

    // R6: -0.5 ns for 10 cycles
    wr(4'd6, 32'hFF800000);
    load_time(32'd0, 32'd5);
    wr(4'd7, 32'd10);
    tick(20);
    rd(4'd0, r); chk(r, 163, "R6 ns after negative adjust");

    // R7: load cancels adjustment
    wr(4'd6, 32'h00800000);
    load_time(32'd0, 32'd5);
    wr(4'd7, 32'd1000);
    tick(3);
    rd(4'd0, r); chk(r, 33, "R7 ns while adjusting");
    wr(4'd0, 32'd500);
    wr(4'd3, 32'd1);
    rd(4'd7, r); chk(r, 0, "R7 remaining cleared");
    rd(4'd0, r); chk(r, 500, "R7 loaded ns");
    tick(10);
    rd(4'd0, r); chk(r, 580, "R7 nominal rate");

    // R8: pulse of width 4 at rollover
    load_time(32'd999999980, 32'd5);
    chk(pps, 0, "R8 pps before");
    tick(2);
    chk(pps, 0, "R8 pps edge before rollover");
    tick(1);
    chk(pps, 1, "R8 pps at rollover");
    rd(4'd1, r); chk(r, 6, "R8 second stepped");
    tick(3);
    chk(pps, 1, "R8 pps last cycle");
    tick(1);
    chk(pps, 0, "R8 pps ended");
    wr(4'd8, 32'd0);
    load_time(32'd999999990, 32'd5);
    tick(2);
    rd(4'd1, r); chk(r, 6, "R8 rollover with zero width");
    chk(pps, 0, "R8 no pulse zero width");
    tick(1);
    chk(pps, 0, "R8 no pulse zero width later");

    // R9: capture
    load_time(32'd0, 32'd5);
    @(negedge clk) align = 1'b1;
    @(posedge clk);
    tick(1);
    rd(4'd0, r); chk(r, 16, "R9 live ns before capture");
    chk(cap_valid, 0, "R9 no strobe yet");
    tick(1);
    chk(cap_valid, 1, "R9 strobe");
    chk(cap_ns, 16, "R9 cap_ns");
    chk(cap_sec, 5, "R9 cap_sec");
    rd(4'd9, r); chk(r, 16, "R9 cap_ns register");
    tick(1);
    chk(cap_valid, 0, "R9 strobe one cycle");

    // R10: high level and falling edge do not capture
    tick(3);
    chk(cap_valid, 0, "R10 held level");
    @(negedge clk) align = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk(cap_valid, 0, "R10 falling edge");
    end
    chk(cap_ns, 16, "R10 capture unchanged");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule